// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is a SPI master that a processor drives through four 32-bit registers on a simple write/read register bus. Each command moves exactly one byte, and the two directions are separate commands. For a write command, software loads the data register and sets the write-start bit; the byte then leaves on MOSI. For a read command, software sets the read-start bit, which clocks eight bits in from MISO. Once the busy flag drops, software collects the byte from the data register.

A configuration register sets four things: the SCK idle level, the bit order, the SCK edge that launches transmit data, and the SCK edge that samples receive data. It also holds a three-bit prescaler code. Codes 0 to 6 give half an SCK period of 2^code system clocks. Code 7 keeps SCK still. The control register drives the single active-low chip select and tri-states MOSI. The register bus has no back-pressure. A write presented with `bus_wr_en` completes at the next clock edge, and read data is a combinational function of `bus_addr`. The SPI pins are plain levels, so no valid/ready stream is involved.

Top module: `bspi_master`

## Requirements
- R1: The byte offsets are: 0x00 status, with busy in bit 0; 0x10 configuration; 0x14 control; 0x20 data. Any other offset reads 0.
  - Configuration reads back: prescaler code in bits [2:0], transmit-on-falling in bit 4, sample-on-falling in bit 5, SCK idle level in bit 6, MSB-first in bit 8. All other bits read 0.
  - Control reads back: enable in bit 0, MOSI high-impedance in bit 3. The start bits (bit 2 write, bit 1 read) always read 0.
  - Data reads back its low 8 bits, with the upper bits 0.
- R2: After reset, configuration reads 0x153, control reads 0x009, status reads 0, SCK is 1, chip select is high and MOSI is not driven.
- R3: An accepted start holds busy at 1 for exactly 2^(code+4) clock cycles, where code is the prescaler code.
- R4: While idle, SCK equals configuration bit 6. During a transfer, SCK toggles once every 2^code cycles, 16 times in all, and ends at its idle level.
- R5: During a write, MOSI presents the data byte from the cycle after acceptance. The order is MSB first when bit 8 is 1 and LSB first otherwise. MOSI advances one bit on each SCK edge in the transmit direction (falling if bit 4 is 1, rising otherwise). After the last bit, and outside write transfers, MOSI is 0.
- R6: During a read, MISO is sampled on each SCK edge in the receive direction (falling if bit 5 is 1, rising otherwise). The eight samples are assembled in the configured bit order. The byte is written into the data register on the same edge that clears busy. MOSI stays 0 throughout.
- R7: A write transfer leaves the data register holding the byte that was sent.
- R8: `spi_cs_n` always equals control bit 0 and `spi_mosi_oe` always equals the inverse of control bit 3, including during a transfer.
- R9: A start bit written while busy is ignored. It neither queues nor changes the running transfer.
- R10: A start issued while the prescaler code is 7 is ignored. Busy stays 0 and SCK stays at its idle level.
- R11: When one write sets both start bits, it starts a write transfer.
- R12: Writes to configuration or data while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_en | input | 1 | Register write strobe, taken at the clock edge |
| bus_addr | input | ADDR_W (6) | Register byte offset for both write and read |
| bus_wdata | input | DATA_W (32) | Register write data |
| bus_rdata | output | DATA_W (32) | Combinational read data for `bus_addr` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_mosi_oe | output | 1 | MOSI output enable; 0 means high impedance |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds the block with its default parameters: a 6-bit offset and a 32-bit bus. It sweeps all sixteen combinations of SCK idle level, transmit edge, receive edge and bit order. These are spread over prescaler codes 0, 1 and 3, so each mode is seen both when SCK toggles every cycle and when each SCK half-period lasts several cycles.

A behavioural reference model is compared with SCK, MOSI, chip select, output enable and the addressed register on every cycle. This reaches the edge cases where the launch and sample edges coincide or where the last transmit edge comes before the end of the transfer. Code 7 is reached only as a start that must be refused.

// File: rtl/bspi_pkg.sv
`timescale 1ns/1ps
package bspi_pkg;
  localparam int unsigned BYTE_BITS = 8;
  localparam int unsigned DIV_W     = 3;

  // byte offsets of the registers
  localparam int unsigned OFS_STATUS  = 'h00;
  localparam int unsigned OFS_CONFIG  = 'h10;
  localparam int unsigned OFS_CONTROL = 'h14;
  localparam int unsigned OFS_DATA    = 'h20;

  // configuration field positions
  localparam int unsigned CB_TXFALL = 4;
  localparam int unsigned CB_RXFALL = 5;
  localparam int unsigned CB_CPOL   = 6;
  localparam int unsigned CB_MSB    = 8;

  // control field positions
  localparam int unsigned KB_EN    = 0;
  localparam int unsigned KB_RD    = 1;
  localparam int unsigned KB_WR    = 2;
  localparam int unsigned KB_HIZ   = 3;

  localparam logic [DIV_W-1:0] DIV_STOP = '1;

  typedef struct packed {
    logic             msb_first;
    logic             cpol;
    logic             rx_fall;
    logic             tx_fall;
    logic [DIV_W-1:0] div;
  } bspi_cfg_t;

  localparam bspi_cfg_t CFG_RESET = '{msb_first: 1'b1, cpol: 1'b1, rx_fall: 1'b0,
                                      tx_fall: 1'b1, div: DIV_W'(3)};
endpackage

// File: rtl/bspi_regs.sv
`timescale 1ns/1ps
module bspi_regs
  import bspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 busy,
  input  logic                 rd_done,
  input  logic [BYTE_BITS-1:0] rx_byte,
  output bspi_cfg_t            cfg,
  output logic                 cs_n,
  output logic                 mosi_hiz,
  output logic                 start_wr,
  output logic                 start_rd,
  output logic [BYTE_BITS-1:0] tx_byte
);
  logic hit_cfg, hit_ctl, hit_data;
  logic [BYTE_BITS-1:0] data_q;
  bspi_cfg_t cfg_q;
  logic en_q, hiz_q;
  logic unused_wbits;

  assign unused_wbits = ^bus_wdata;

  assign hit_cfg  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CONFIG));
  assign hit_ctl  = bus_wr_en && (bus_addr == ADDR_W'(OFS_CONTROL));
  assign hit_data = bus_wr_en && (bus_addr == ADDR_W'(OFS_DATA));

  // write command takes priority when both start bits are set
  assign start_wr = hit_ctl && bus_wdata[KB_WR];
  assign start_rd = hit_ctl && bus_wdata[KB_RD] && !bus_wdata[KB_WR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_RESET;
      en_q   <= 1'b1;
      hiz_q  <= 1'b1;
      data_q <= '0;
    end else begin
      if (hit_ctl) begin
        en_q  <= bus_wdata[KB_EN];
        hiz_q <= bus_wdata[KB_HIZ];
      end
      if (hit_cfg && !busy) begin
        cfg_q.msb_first <= bus_wdata[CB_MSB];
        cfg_q.cpol      <= bus_wdata[CB_CPOL];
        cfg_q.rx_fall   <= bus_wdata[CB_RXFALL];
        cfg_q.tx_fall   <= bus_wdata[CB_TXFALL];
        cfg_q.div       <= bus_wdata[DIV_W-1:0];
      end
      if (rd_done)
        data_q <= rx_byte;
      else if (hit_data && !busy)
        data_q <= bus_wdata[BYTE_BITS-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_STATUS)) begin
      bus_rdata[0] = busy;
    end else if (bus_addr == ADDR_W'(OFS_CONFIG)) begin
      bus_rdata[DIV_W-1:0] = cfg_q.div;
      bus_rdata[CB_TXFALL] = cfg_q.tx_fall;
      bus_rdata[CB_RXFALL] = cfg_q.rx_fall;
      bus_rdata[CB_CPOL]   = cfg_q.cpol;
      bus_rdata[CB_MSB]    = cfg_q.msb_first;
    end else if (bus_addr == ADDR_W'(OFS_CONTROL)) begin
      bus_rdata[KB_EN]  = en_q;
      bus_rdata[KB_HIZ] = hiz_q;
    end else if (bus_addr == ADDR_W'(OFS_DATA)) begin
      bus_rdata[BYTE_BITS-1:0] = data_q;
    end
  end

  assign cfg      = cfg_q;
  assign cs_n     = en_q;
  assign mosi_hiz = hiz_q;
  assign tx_byte  = data_q;

  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));
  // R12
  data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_done) |=> $stable(data_q));
endmodule

// File: rtl/bspi_clkgen.sv
`timescale 1ns/1ps
module bspi_clkgen #(
  parameter int DIV_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int CNT_W = (1 << DIV_W) - 2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << div) - CNT_W'(1);
  assign tick = run && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (!run || tick)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4
  half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (cnt_q != '0) || !run);
endmodule

// File: rtl/bspi_shifter.sv
`timescale 1ns/1ps
module bspi_shifter
  import bspi_pkg::*;
#(
  parameter int BITS = BYTE_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_wr,
  input  logic            start_rd,
  input  bspi_cfg_t       cfg,
  input  logic [BITS-1:0] tx_byte,
  input  logic            tick,
  input  logic            miso,
  output logic            busy,
  output logic            sck_q,
  output logic            mosi,
  output logic [BITS-1:0] rx_next,
  output logic            rd_done
);
  localparam int EDGE_W = $clog2(2 * BITS);
  localparam logic [EDGE_W-1:0] LAST_EDGE = EDGE_W'(2 * BITS - 1);

  logic            busy_q, is_wr;
  logic [BITS-1:0] tx_q, rx_q;
  logic [EDGE_W-1:0] edge_cnt;
  logic accept, tx_edge, rx_edge, last;

  assign accept  = !busy_q && (start_wr || start_rd) && (cfg.div != DIV_STOP);
  // sck_q high before the toggle means the coming edge is falling
  assign tx_edge = tick && (sck_q == cfg.tx_fall);
  assign rx_edge = tick && (sck_q == cfg.rx_fall);
  assign last    = tick && (edge_cnt == LAST_EDGE);
  assign rd_done = last && !is_wr;

  always_comb begin
    rx_next = rx_q;
    if (rx_edge && !is_wr)
      rx_next = cfg.msb_first ? {rx_q[BITS-2:0], miso} : {miso, rx_q[BITS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      is_wr    <= 1'b0;
      sck_q    <= 1'b1;
      tx_q     <= '0;
      rx_q     <= '0;
      edge_cnt <= '0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      is_wr    <= start_wr;
      sck_q    <= cfg.cpol;
      tx_q     <= tx_byte;
      rx_q     <= '0;
      edge_cnt <= '0;
    end else if (busy_q) begin
      rx_q <= rx_next;
      if (tick) begin
        sck_q    <= ~sck_q;
        edge_cnt <= edge_cnt + EDGE_W'(1);
        if (tx_edge && is_wr)
          tx_q <= cfg.msb_first ? {tx_q[BITS-2:0], 1'b0} : {1'b0, tx_q[BITS-1:1]};
        if (last)
          busy_q <= 1'b0;
      end
    end
  end

  assign busy = busy_q;
  assign mosi = (busy_q && is_wr) ? (cfg.msb_first ? tx_q[BITS-1] : tx_q[0]) : 1'b0;

  // R3
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(edge_cnt) == LAST_EDGE) && $past(tick));
  // R9
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start_wr || start_rd));
  // R10
  stop_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && cfg.div == DIV_STOP) |=> !busy_q);
  // R4
  sck_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick) |=> $stable(sck_q));
endmodule

// File: rtl/bspi_master.sv
`timescale 1ns/1ps
module bspi_master
  import bspi_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  input  logic              spi_miso
);
  bspi_cfg_t cfg;
  logic busy, rd_done, start_wr, start_rd, tick, sck_q, hiz;
  logic [BYTE_BITS-1:0] rx_next, tx_byte;

  bspi_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .rd_done(rd_done),
    .rx_byte(rx_next), .cfg(cfg), .cs_n(spi_cs_n), .mosi_hiz(hiz),
    .start_wr(start_wr), .start_rd(start_rd), .tx_byte(tx_byte));

  bspi_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(cfg.div), .tick(tick));

  bspi_shifter #(.BITS(BYTE_BITS)) u_shift (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .start_rd(start_rd), .cfg(cfg),
    .tx_byte(tx_byte), .tick(tick), .miso(spi_miso), .busy(busy), .sck_q(sck_q),
    .mosi(spi_mosi), .rx_next(rx_next), .rd_done(rd_done));

  assign spi_sck     = busy ? sck_q : cfg.cpol;
  assign spi_mosi_oe = !hiz;

  // R8
  cs_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && bus_addr == ADDR_W'(OFS_CONTROL)) |=> (spi_cs_n == $past(bus_wdata[KB_EN])));
endmodule

// File: tb/sim_bspi_master.sv
`timescale 1ns/1ps
module sim_bspi_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr_en = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic spi_sck, spi_cs_n, spi_mosi, spi_mosi_oe, spi_miso;
  logic [1:0] miso_mode = 2'd2;
  logic [15:0] lfsr = 16'hACE1;
  int n_chk = 0, n_fail = 0;
  bit fin = 0;

  always #2 clk = ~clk;

  bspi_master u0 (.clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_mosi_oe(spi_mosi_oe), .spi_miso(spi_miso));

  always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  assign spi_miso = (miso_mode == 2'd2) ? lfsr[0] : miso_mode[0];

  // reference model
  bit m_busy, m_wr, m_sck, m_en, m_hiz, m_fall, m_sw, m_sr;
  logic [7:0] m_data, n_data;
  logic [8:0] m_cfgw, n_cfgw;
  int m_cnt, m_edges, m_half;
  bit txq[$];
  bit rxq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_wr = 0; m_sck = 1; m_en = 1; m_hiz = 1; m_data = 0; m_cfgw = 9'h153;
      m_cnt = 0; m_edges = 0; m_half = 1;
    end else begin
      m_sw = 0; m_sr = 0; n_data = m_data; n_cfgw = m_cfgw;
      if (bus_wr_en) begin
        if (bus_addr == 6'h14) begin
          m_en = bus_wdata[0]; m_hiz = bus_wdata[3];
          m_sw = bus_wdata[2]; m_sr = bus_wdata[1] && !bus_wdata[2];
        end
        if (bus_addr == 6'h10 && !m_busy) n_cfgw = bus_wdata[8:0] & 9'h177;
        if (bus_addr == 6'h20 && !m_busy) n_data = bus_wdata[7:0];
      end
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == m_half) begin
          m_cnt = 0; m_fall = m_sck; m_sck = !m_sck; m_edges++;
          if (m_wr && m_fall == m_cfgw[4] && txq.size() > 0) void'(txq.pop_front());
          if (!m_wr && m_fall == m_cfgw[5]) rxq.push_back(spi_miso);
          if (m_edges == 16) begin
            m_busy = 0;
            if (!m_wr) for (int i = 0; i < 8; i++)
              if (m_cfgw[8]) n_data[7-i] = rxq[i]; else n_data[i] = rxq[i];
          end
        end
      end else if ((m_sw || m_sr) && m_cfgw[2:0] != 3'd7) begin
        m_busy = 1; m_wr = m_sw; m_cnt = 0; m_edges = 0; m_sck = m_cfgw[6];
        m_half = 1 << m_cfgw[2:0];
        txq.delete(); rxq.delete();
        for (int i = 0; i < 8; i++) txq.push_back(m_cfgw[8] ? m_data[7-i] : m_data[i]);
      end
      m_data = n_data; m_cfgw = n_cfgw;
    end
  end

  function automatic logic [31:0] exp_reg(logic [5:0] a);
    case (a)
      6'h00: return {31'd0, m_busy};
      6'h10: return {23'd0, m_cfgw};
      6'h14: return {28'd0, m_hiz, 2'b00, m_en};
      6'h20: return {24'd0, m_data};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n && !fin) begin
      chk(spi_sck === (m_busy ? m_sck : m_cfgw[6]), "R4", "sck", spi_sck, m_busy ? m_sck : m_cfgw[6]);
      chk(spi_mosi === ((m_busy && m_wr && txq.size() > 0) ? txq[0] : 1'b0), "R5", "mosi",
          spi_mosi, (m_busy && m_wr && txq.size() > 0) ? txq[0] : 1'b0);
      chk(spi_cs_n === m_en, "R8", "cs_n", spi_cs_n, m_en);
      chk(spi_mosi_oe === !m_hiz, "R8", "mosi_oe", spi_mosi_oe, !m_hiz);
      case (bus_addr)
        6'h00: chk(bus_rdata === exp_reg(bus_addr), "R3", "status", bus_rdata, exp_reg(bus_addr));
        6'h20: chk(bus_rdata === exp_reg(bus_addr), "R6", "data", bus_rdata, exp_reg(bus_addr));
        default: chk(bus_rdata === exp_reg(bus_addr), "R1", "reg", bus_rdata, exp_reg(bus_addr));
      endcase
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_wr_en = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr_en = 0;
  endtask

  task automatic peek(logic [5:0] a, logic [31:0] exp, string tag);
    bus_addr = a; #1;
    chk(bus_rdata === exp, tag, "peek", bus_rdata, exp);
  endtask

  task automatic wait_idle();
    bus_addr = 6'h00; #1;
    for (int i = 0; i < 5000 && bus_rdata[0]; i++) begin @(negedge clk); #1; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      fin = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset state
    peek(6'h10, 32'h153, "R2"); peek(6'h14, 32'h009, "R2"); peek(6'h00, 32'h0, "R2");
    chk(spi_sck === 1'b1, "R2", "sck", spi_sck, 1); chk(spi_cs_n === 1'b1, "R2", "cs_n", spi_cs_n, 1);
    chk(spi_mosi_oe === 1'b0, "R2", "oe", spi_mosi_oe, 0);
    wr(6'h14, 32'h0);
    chk(spi_cs_n === 1'b0 && spi_mosi_oe === 1'b1, "R8", "cs/oe", {spi_cs_n, spi_mosi_oe}, 2'b01);
    // mode sweep: write then read in each of 16 modes
    for (int k = 0; k < 16; k++) begin
      logic [2:0] dv; logic [7:0] b;
      dv = (k % 3 == 2) ? 3'd3 : 3'(k % 3);
      b = 8'h5A ^ 8'(k * 37);
      wr(6'h10, {23'd0, k[3], 1'b0, k[0], k[2], k[1], 1'b0, dv});
      wr(6'h20, {24'd0, b});
      wr(6'h14, 32'h4);
      wait_idle();
      peek(6'h20, {24'd0, b}, "R7");
      wr(6'h14, 32'h2);
      wait_idle();
    end
    // R6 constant MISO
    wr(6'h10, 32'h100);
    miso_mode = 2'd1; wr(6'h14, 32'h2); wait_idle(); peek(6'h20, 32'hFF, "R6");
    miso_mode = 2'd0; wr(6'h14, 32'h2); wait_idle(); peek(6'h20, 32'h00, "R6");
    // R3 busy duration with code 1
    wr(6'h10, 32'h101); wr(6'h14, 32'h4);
    begin
      int n; n = 0; bus_addr = 6'h00; #1;
      while (bus_rdata[0] && n < 1000) begin n++; @(negedge clk); #1; end
      chk(n == 32, "R3", "busy cycles", n, 32);
    end
    // R12 writes while busy ignored
    wr(6'h20, 32'h3C); wr(6'h14, 32'h4); wr(6'h20, 32'hFF); wr(6'h10, 32'h177);
    wait_idle(); peek(6'h20, 32'h3C, "R12"); peek(6'h10, 32'h101, "R12");
    // R9 start while busy ignored
    wr(6'h20, 32'h96); wr(6'h14, 32'h4); wr(6'h14, 32'h2);
    wait_idle(); @(negedge clk); peek(6'h00, 32'h0, "R9"); peek(6'h20, 32'h96, "R9");
    // R11 both start bits give a write
    wr(6'h10, 32'h100); wr(6'h20, 32'h81); wr(6'h14, 32'h6);
    wait_idle(); peek(6'h20, 32'h81, "R11");
    // R8 chip select and tri-state follow control while busy
    wr(6'h14, 32'h8); chk(spi_mosi_oe === 1'b0, "R8", "hiz", spi_mosi_oe, 0);
    wr(6'h14, 32'h5);
    chk(spi_cs_n === 1'b1, "R8", "cs during busy", spi_cs_n, 1);
    peek(6'h00, 32'h1, "R8");
    wait_idle();
    // R10 code 7 refuses start
    wr(6'h10, 32'h047); wr(6'h14, 32'h4);
    peek(6'h00, 32'h0, "R10"); chk(spi_sck === 1'b1, "R10", "sck idle", spi_sck, 1);
    // R1 map and readback masks
    peek(6'h04, 32'h0, "R1"); peek(6'h24, 32'h0, "R1");
    wr(6'h10, 32'hFFFF_FFFF); peek(6'h10, 32'h177, "R1");
    wr(6'h14, 32'hFFFF_FFFE); peek(6'h14, 32'h8, "R1"); peek(6'h00, 32'h0, "R1");
    wr(6'h20, 32'hFFFF_FF12); peek(6'h20, 32'h12, "R1");
    repeat (4) @(negedge clk);
    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule